// File: doc/BRIEF.md
# Line-Card Flow Forwarding Cache

This block is the fast front-end lookup of a line card. Each packet is looked up by its IPv4 source and destination address pair before the full forwarding table is ever consulted. A flow whose entry is complete gets its egress port, next-hop MAC rewrite value, priority queue, discard profile and priority remark value straight from the cache. Anything else is flagged for punting to the route processor.

The first packet of a new flow misses. The cache then writes a key-only placeholder for that flow straight away, so the route processor only has to supply the forwarding data later. When the route processor has resolved the flow, it presents a completion on a separate port. The completion fills the placeholder and marks it complete, and later packets of the flow are forwarded locally. Packets addressed to the router itself, packets that need fragmentation and packets that carry IP options are always punted, even on a hit.

The array is set-associative, 64 sets by 4 ways by default, and the set is chosen by hashing the address pair. A global invalidate sweeps the valid bits clear one set per cycle.

Top module: `flow_route_cache`

## Requirements
- R1: A lookup sampled at one rising edge returns its result at the next rising edge but one. `res_valid` is high for exactly that one cycle per lookup.
- R2: The set index is the XOR-fold of (src XOR dst). Bit i of that 32-bit value is XORed into index bit (i mod log2(SETS)).
- R3: A lookup that matches a complete entry, with none of the three special flags set, returns res_hit=1 and res_punt=0. It also returns that entry's port, MAC, queue, discard profile and remark.
- R4: A lookup that matches no valid entry returns res_hit=0 and res_punt=1 with all forwarding outputs zero. It also writes an incomplete entry holding only the address pair.
- R5: A lookup that matches an incomplete entry returns res_hit=0, res_punt=1 and zero forwarding outputs, and allocates no second entry. This also holds for two lookups of a new flow in back-to-back cycles.
- R6: A completion whose address pair matches a valid entry fills that entry's forwarding data and marks it complete. A completion that matches no entry allocates a new complete entry.
- R7: A lookup with to_self, needs_frag or has_options set returns res_punt=1 even when it hits a complete entry. In that case it still reports res_hit=1 and the entry's forwarding data.
- R8: An allocation takes the lowest-numbered invalid way of the set. If every way is valid, it takes the way named by that set's round-robin pointer (0 after reset), and the pointer then advances by one, wrapping after the last way.
- R9: When a completion and a lookup reach the decision stage in the same cycle, the completion owns the single write. The lookup is judged on the array contents before that write and allocates nothing.
- R10: After inv_all is sampled while idle, flush_busy is high for exactly SETS cycles, and afterwards every entry is invalid. During that time lookups report res_hit=0 and res_punt=1 and allocate nothing, completions are discarded, and a further inv_all is ignored.
- R11: After reset, res_valid and flush_busy are low and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | Lookup request strobe |
| lkp_src | input | 32 | Lookup IPv4 source address |
| lkp_dst | input | 32 | Lookup IPv4 destination address |
| lkp_to_self | input | 1 | Packet is addressed to this router |
| lkp_frag | input | 1 | Packet needs fragmentation |
| lkp_opts | input | 1 | Packet carries IP options |
| res_valid | output | 1 | Lookup result strobe |
| res_hit | output | 1 | A complete entry matched |
| res_punt | output | 1 | Packet must go to the route processor |
| res_port | output | 4 | Egress port |
| res_mac | output | 48 | Next-hop MAC rewrite value |
| res_queue | output | 3 | Priority queue |
| res_drop | output | 2 | Discard profile |
| res_remark | output | 3 | Priority remark value |
| cmp_valid | input | 1 | Completion write strobe |
| cmp_src | input | 32 | Completion source address |
| cmp_dst | input | 32 | Completion destination address |
| cmp_port | input | 4 | Completion egress port |
| cmp_mac | input | 48 | Completion MAC rewrite value |
| cmp_queue | input | 3 | Completion priority queue |
| cmp_drop | input | 2 | Completion discard profile |
| cmp_remark | input | 3 | Completion remark value |
| inv_all | input | 1 | Start invalidation of the whole cache |
| flush_busy | output | 1 | Invalidation sweep in progress |

## Verification
Two functions can fall in the same cycle: a lookup that would allocate an entry and a completion that must write one. The bench presents a lookup and a completion for the same brand-new flow on the same clock edge. The lookup must report a punt without a hit, and a later lookup of that flow must hit with the completion's data. That result shows the completion won the write and the lookup left no stale placeholder. Back-to-back lookups of one new flow provoke the related read-during-write case, and the single-match assertion judges it.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int ADDR_W   = 32;
  localparam int PORT_W   = 4;
  localparam int MAC_W    = 48;
  localparam int QUEUE_W  = 3;
  localparam int DROP_W   = 2;
  localparam int REMARK_W = 3;

  typedef struct packed {
    logic [PORT_W-1:0]   port;
    logic [MAC_W-1:0]    mac;
    logic [QUEUE_W-1:0]  queue;
    logic [DROP_W-1:0]   drop;
    logic [REMARK_W-1:0] remark;
  } fwd_t;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic              done;
    fwd_t              fwd;
  } entry_t;

  localparam int ENT_W = $bits(entry_t);
endpackage

// File: rtl/fc_way_ram.sv
// One way of the cache: single write port, two synchronous read ports,
// read-before-write, shaped for block RAM inference.
module fc_way_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    ra_addr,
  output logic [WIDTH-1:0] ra_data,
  input  logic [AW-1:0]    rb_addr,
  output logic [WIDTH-1:0] rb_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/fc_victim.sv
// Picks the way to fill: lowest invalid way, else the round-robin pointer.
module fc_victim #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]  valid_row,
  input  logic [WAY_W-1:0] rr_ptr,
  output logic [WAY_W-1:0] way,
  output logic             use_rr
);
  always_comb begin
    way    = rr_ptr;
    use_rr = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_row[w]) begin
        way    = WAY_W'(w);
        use_rr = 1'b0;
      end
    end
  end
endmodule

// File: rtl/fc_sweep.sv
// Invalidation sweep: one set index per cycle, SETS cycles in total.
module fc_sweep #(
  parameter int SETS = 64,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (!busy) begin
      idx <= '0;
      if (start) busy <= 1'b1;
    end else if (idx == IDX_W'(SETS - 1)) begin
      busy <= 1'b0;
    end else begin
      idx <= idx + 1'b1;
    end
  end

  // R10: every sweep begins at set zero
  a_r10_sweep_from_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> idx == '0);
endmodule

// File: rtl/flow_route_cache.sv
module flow_route_cache
  import fc_pkg::*;
#(
  parameter int SETS = 64,
  parameter int WAYS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lkp_valid,
  input  logic [ADDR_W-1:0]   lkp_src,
  input  logic [ADDR_W-1:0]   lkp_dst,
  input  logic                lkp_to_self,
  input  logic                lkp_frag,
  input  logic                lkp_opts,
  output logic                res_valid,
  output logic                res_hit,
  output logic                res_punt,
  output logic [PORT_W-1:0]   res_port,
  output logic [MAC_W-1:0]    res_mac,
  output logic [QUEUE_W-1:0]  res_queue,
  output logic [DROP_W-1:0]   res_drop,
  output logic [REMARK_W-1:0] res_remark,
  input  logic                cmp_valid,
  input  logic [ADDR_W-1:0]   cmp_src,
  input  logic [ADDR_W-1:0]   cmp_dst,
  input  logic [PORT_W-1:0]   cmp_port,
  input  logic [MAC_W-1:0]    cmp_mac,
  input  logic [QUEUE_W-1:0]  cmp_queue,
  input  logic [DROP_W-1:0]   cmp_drop,
  input  logic [REMARK_W-1:0] cmp_remark,
  input  logic                inv_all,
  output logic                flush_busy
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  function automatic logic [IDX_W-1:0] set_of(input logic [ADDR_W-1:0] a,
                                              input logic [ADDR_W-1:0] b);
    logic [ADDR_W-1:0] x;
    set_of = '0;
    x = a ^ b;
    for (int i = 0; i < ADDR_W; i++) set_of[i % IDX_W] ^= x[i];
  endfunction

  // ---------------- stage 1: request registers ----------------
  logic              s1l_v, s1l_spec;
  logic [ADDR_W-1:0] s1l_src, s1l_dst;
  logic [IDX_W-1:0]  s1l_idx;
  logic              s1c_v;
  logic [ADDR_W-1:0] s1c_src, s1c_dst;
  logic [IDX_W-1:0]  s1c_idx;
  fwd_t              s1c_fwd;
  logic [IDX_W-1:0]  lkp_idx_in, cmp_idx_in;

  assign lkp_idx_in = set_of(lkp_src, lkp_dst);
  assign cmp_idx_in = set_of(cmp_src, cmp_dst);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1l_v <= 1'b0;
      s1c_v <= 1'b0;
    end else begin
      s1l_v <= lkp_valid;
      s1c_v <= cmp_valid;
    end
    s1l_src  <= lkp_src;
    s1l_dst  <= lkp_dst;
    s1l_idx  <= lkp_idx_in;
    s1l_spec <= lkp_to_self | lkp_frag | lkp_opts;
    s1c_src  <= cmp_src;
    s1c_dst  <= cmp_dst;
    s1c_idx  <= cmp_idx_in;
    s1c_fwd  <= '{port: cmp_port, mac: cmp_mac, queue: cmp_queue,
                  drop: cmp_drop, remark: cmp_remark};
  end

  // ---------------- storage ----------------
  logic [ENT_W-1:0] ra_q [WAYS];
  logic [ENT_W-1:0] rb_q [WAYS];
  logic             wr_en, wr_rr;
  logic [IDX_W-1:0] wr_idx;
  logic [WAY_W-1:0] wr_way;
  entry_t           wr_ent;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    fc_way_ram #(.DEPTH(SETS), .WIDTH(ENT_W)) u_ram (
      .clk     (clk),
      .we      (wr_en && (wr_way == WAY_W'(w))),
      .waddr   (wr_idx),
      .wdata   (wr_ent),
      .ra_addr (lkp_idx_in),
      .ra_data (ra_q[w]),
      .rb_addr (cmp_idx_in),
      .rb_data (rb_q[w])
    );
  end

  logic [WAYS-1:0]  valid [SETS];
  logic [WAY_W-1:0] rr    [SETS];
  logic [IDX_W-1:0] clr_idx;

  // write performed at the edge the RAMs were read: forwarded
  logic             byp_v;
  logic [IDX_W-1:0] byp_idx;
  logic [WAY_W-1:0] byp_way;
  entry_t           byp_ent;

  // ---------------- stage 2: compare ----------------
  entry_t           l_ent [WAYS];
  entry_t           c_ent [WAYS];
  logic [WAYS-1:0]  l_match, c_match;
  entry_t           l_sel;
  logic [WAY_W-1:0] c_mway;
  logic             l_hit, l_alloc, c_go;
  logic [WAY_W-1:0] l_vway, c_vway;
  logic             l_vrr, c_vrr;

  always_comb begin
    l_sel  = '0;
    c_mway = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      l_ent[w] = (byp_v && byp_idx == s1l_idx && byp_way == WAY_W'(w))
                 ? byp_ent : entry_t'(ra_q[w]);
      c_ent[w] = (byp_v && byp_idx == s1c_idx && byp_way == WAY_W'(w))
                 ? byp_ent : entry_t'(rb_q[w]);
      l_match[w] = valid[s1l_idx][w] && l_ent[w].src == s1l_src &&
                   l_ent[w].dst == s1l_dst;
      c_match[w] = valid[s1c_idx][w] && c_ent[w].src == s1c_src &&
                   c_ent[w].dst == s1c_dst;
      if (l_match[w]) l_sel  = l_ent[w];
      if (c_match[w]) c_mway = WAY_W'(w);
    end
  end

  fc_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_lvict (
    .valid_row (valid[s1l_idx]), .rr_ptr (rr[s1l_idx]),
    .way (l_vway), .use_rr (l_vrr));

  fc_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_cvict (
    .valid_row (valid[s1c_idx]), .rr_ptr (rr[s1c_idx]),
    .way (c_vway), .use_rr (c_vrr));

  assign c_go    = s1c_v && !flush_busy;
  assign l_hit   = s1l_v && !flush_busy && (|l_match) && l_sel.done;
  assign l_alloc = s1l_v && !flush_busy && !(|l_match);

  // single write port: a completion always wins it
  always_comb begin
    wr_en  = 1'b0;
    wr_rr  = 1'b0;
    wr_idx = s1l_idx;
    wr_way = l_vway;
    wr_ent = '0;
    if (c_go) begin
      wr_en       = 1'b1;
      wr_idx      = s1c_idx;
      wr_way      = (|c_match) ? c_mway : c_vway;
      wr_rr       = !(|c_match) && c_vrr;
      wr_ent.src  = s1c_src;
      wr_ent.dst  = s1c_dst;
      wr_ent.done = 1'b1;
      wr_ent.fwd  = s1c_fwd;
    end else if (l_alloc) begin
      wr_en      = 1'b1;
      wr_rr      = l_vrr;
      wr_ent.src = s1l_src;
      wr_ent.dst = s1l_dst;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_v <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        valid[s] <= '0;
        rr[s]    <= '0;
      end
    end else begin
      byp_v <= wr_en;
      if (flush_busy) valid[clr_idx] <= '0;
      if (wr_en) valid[wr_idx][wr_way] <= 1'b1;
      if (wr_rr)
        rr[wr_idx] <= (rr[wr_idx] == WAY_W'(WAYS - 1)) ? '0 : rr[wr_idx] + 1'b1;
    end
    byp_idx <= wr_idx;
    byp_way <= wr_way;
    byp_ent <= wr_ent;
  end

  fc_sweep #(.SETS(SETS)) u_sweep (
    .clk (clk), .rst (rst), .start (inv_all),
    .busy (flush_busy), .idx (clr_idx));

  // ---------------- result registers ----------------
  fwd_t res_fwd;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_punt  <= 1'b0;
      res_fwd   <= '0;
    end else begin
      res_valid <= s1l_v;
      res_hit   <= l_hit;
      res_punt  <= s1l_v && (!l_hit || s1l_spec);
      res_fwd   <= l_hit ? l_sel.fwd : '0;
    end
  end

  assign res_port   = res_fwd.port;
  assign res_mac    = res_fwd.mac;
  assign res_queue  = res_fwd.queue;
  assign res_drop   = res_fwd.drop;
  assign res_remark = res_fwd.remark;

  // ---------------- checks ----------------
  logic any_valid;
  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < SETS; s++) any_valid |= |valid[s];
  end

  // R1: result strobe follows the request strobe two edges later
  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    res_valid == $past(lkp_valid, 2));

  // R5: a flow never occupies two ways of its set
  a_r5_single_match: assert property (@(posedge clk) disable iff (rst)
    (s1l_v |-> $onehot0(l_match)) and (s1c_v |-> $onehot0(c_match)));

  // R6: a completion always leaves a complete entry behind
  a_r6_completion_done: assert property (@(posedge clk) disable iff (rst)
    (s1c_v && !flush_busy) |=> (byp_v && byp_ent.done));

  // R10: the sweep leaves no valid entry
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(flush_busy) |-> !any_valid);

  // R7: a local forward is only reported for a hit
  a_r7_forward_needs_hit: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_punt) |-> res_hit);
endmodule

// File: tb/tb_flow_route_cache.sv
module tb_flow_route_cache;
  import fc_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic                lkp_valid = 0, lkp_to_self = 0, lkp_frag = 0, lkp_opts = 0;
  logic [31:0]         lkp_src = 0, lkp_dst = 0;
  logic                res_valid, res_hit, res_punt;
  logic [PORT_W-1:0]   res_port;
  logic [MAC_W-1:0]    res_mac;
  logic [QUEUE_W-1:0]  res_queue;
  logic [DROP_W-1:0]   res_drop;
  logic [REMARK_W-1:0] res_remark;
  logic                cmp_valid = 0;
  logic [31:0]         cmp_src = 0, cmp_dst = 0;
  fwd_t                cmp_fwd = '0;
  logic                inv_all = 0;
  logic                flush_busy;

  flow_route_cache dut (
    .clk (clk), .rst (rst),
    .lkp_valid (lkp_valid), .lkp_src (lkp_src), .lkp_dst (lkp_dst),
    .lkp_to_self (lkp_to_self), .lkp_frag (lkp_frag), .lkp_opts (lkp_opts),
    .res_valid (res_valid), .res_hit (res_hit), .res_punt (res_punt),
    .res_port (res_port), .res_mac (res_mac), .res_queue (res_queue),
    .res_drop (res_drop), .res_remark (res_remark),
    .cmp_valid (cmp_valid), .cmp_src (cmp_src), .cmp_dst (cmp_dst),
    .cmp_port (cmp_fwd.port), .cmp_mac (cmp_fwd.mac), .cmp_queue (cmp_fwd.queue),
    .cmp_drop (cmp_fwd.drop), .cmp_remark (cmp_fwd.remark),
    .inv_all (inv_all), .flush_busy (flush_busy));

  int n_chk = 0, n_fail = 0, busy_cnt = 0;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [62:0] result_now();
    return {res_valid, res_hit, res_punt, res_port, res_mac, res_queue, res_drop, res_remark};
  endfunction

  task automatic expect_lk(string tag, logic [31:0] s, logic [31:0] d, logic [2:0] flg,
                           logic ehit, logic epunt, fwd_t efwd);
    @(negedge clk);
    lkp_valid = 1; lkp_src = s; lkp_dst = d;
    {lkp_to_self, lkp_frag, lkp_opts} = flg;
    @(negedge clk);
    lkp_valid = 0; {lkp_to_self, lkp_frag, lkp_opts} = 3'b000;
    @(negedge clk);
    check(tag, result_now(), {1'b1, ehit, epunt, efwd});
  endtask

  task automatic complete(logic [31:0] s, logic [31:0] d, fwd_t f);
    @(negedge clk);
    cmp_valid = 1; cmp_src = s; cmp_dst = d; cmp_fwd = f;
    @(negedge clk);
    cmp_valid = 0;
    @(negedge clk);
  endtask

  // destination that lands in set s (source 0), per the R2 fold
  function automatic logic [31:0] dsel(int s, int k);
    return 32'((k << 6) | ((k ^ s) & 63));
  endfunction

  function automatic fwd_t mkf(int p);
    return '{port: 4'(p), mac: 48'h02_00_00_00_00_00 + 48'(p),
             queue: 3'(p), drop: 2'(p), remark: 3'(p + 1)};
  endfunction

  typedef struct packed {
    logic        is_cmp;
    logic [31:0] src;
    logic [31:0] dst;
    logic [2:0]  flg;   // {to_self, frag, options}
    fwd_t        fwd;
    logic        ehit;
    logic        epunt;
  } vec_t;

  localparam fwd_t Z0 = '0;
  localparam fwd_t FA = '{port: 4'd5, mac: 48'h001122334455, queue: 3'd3, drop: 2'd1, remark: 3'd6};
  localparam fwd_t FB = '{port: 4'd9, mac: 48'h0A0B0C0D0E0F, queue: 3'd7, drop: 2'd2, remark: 3'd1};
  localparam logic [31:0] S1 = 32'h0A000001, D1 = 32'h0A000002;
  localparam logic [31:0] S2 = 32'hC0A80001, D2 = 32'hC0A80063;

  localparam vec_t VT [9] = '{
    '{1'b0, S1, D1, 3'b000, Z0, 1'b0, 1'b1},  // R11 R4: empty cache misses, key-only entry made
    '{1'b0, S1, D1, 3'b000, Z0, 1'b0, 1'b1},  // R5: incomplete entry still punts
    '{1'b1, S1, D1, 3'b000, FA, 1'b0, 1'b0},  // R6: completion fills the placeholder
    '{1'b0, S1, D1, 3'b000, FA, 1'b1, 1'b0},  // R3: complete hit forwards locally
    '{1'b0, S1, D1, 3'b100, FA, 1'b1, 1'b1},  // R7: to_self punts on hit
    '{1'b0, S1, D1, 3'b010, FA, 1'b1, 1'b1},  // R7: fragmentation punts on hit
    '{1'b0, S1, D1, 3'b001, FA, 1'b1, 1'b1},  // R7: options punt on hit
    '{1'b1, S2, D2, 3'b000, FB, 1'b0, 1'b0},  // R6: completion without placeholder
    '{1'b0, S2, D2, 3'b000, FB, 1'b1, 1'b0}   // R6: allocated complete entry hits
  };

  always @(negedge clk) if (flush_busy) busy_cnt++;

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R11 reset res_valid", 128'(res_valid), 128'(0));
    check("R11 reset flush_busy", 128'(flush_busy), 128'(0));

    for (int i = 0; i < 9; i++) begin
      if (VT[i].is_cmp) complete(VT[i].src, VT[i].dst, VT[i].fwd);
      else expect_lk($sformatf("table row %0d", i), VT[i].src, VT[i].dst, VT[i].flg,
                     VT[i].ehit, VT[i].epunt, VT[i].fwd);
    end

    // R8 R2: four flows folded into set 20 fill ways 0..3, then round robin
    for (int k = 1; k <= 4; k++) complete(0, dsel(20, k), mkf(k));
    expect_lk("R8 fifth flow misses", 0, dsel(20, 5), 3'b000, 0, 1, Z0);
    expect_lk("R8 way1 flow kept", 0, dsel(20, 2), 3'b000, 1, 0, mkf(2));
    expect_lk("R8 way0 flow evicted", 0, dsel(20, 1), 3'b000, 0, 1, Z0);
    expect_lk("R8 way1 evicted next", 0, dsel(20, 2), 3'b000, 0, 1, Z0);
    expect_lk("R8 way3 flow kept", 0, dsel(20, 4), 3'b000, 1, 0, mkf(4));

    // R5: back-to-back lookups of one new flow
    @(negedge clk);
    lkp_valid = 1; lkp_src = 0; lkp_dst = dsel(40, 1);
    @(negedge clk);
    @(negedge clk);
    lkp_valid = 0;
    check("R5 first back-to-back miss", result_now(), {3'b101, Z0});
    @(negedge clk);
    check("R5 second back-to-back miss", result_now(), {3'b101, Z0});
    complete(0, dsel(40, 1), mkf(7));
    expect_lk("R5 single placeholder completed", 0, dsel(40, 1), 3'b000, 1, 0, mkf(7));

    // R9: lookup and completion of the same new flow on one edge
    @(negedge clk);
    lkp_valid = 1; lkp_src = 0; lkp_dst = dsel(50, 1);
    cmp_valid = 1; cmp_src = 0; cmp_dst = dsel(50, 1); cmp_fwd = mkf(11);
    @(negedge clk);
    lkp_valid = 0; cmp_valid = 0;
    @(negedge clk);
    check("R9 concurrent lookup punts", result_now(), {3'b101, Z0});
    expect_lk("R9 completion won the write", 0, dsel(50, 1), 3'b000, 1, 0, mkf(11));

    // R10: invalidate all
    busy_cnt = 0;
    @(negedge clk);
    inv_all = 1;
    @(negedge clk);
    inv_all = 0;
    check("R10 flush_busy raised", 128'(flush_busy), 128'(1));
    expect_lk("R10 lookup during flush punts", S1, D1, 3'b000, 0, 1, Z0);
    complete(0, dsel(60, 1), mkf(3));
    @(negedge clk);
    inv_all = 1;
    @(negedge clk);
    inv_all = 0;
    while (flush_busy) @(negedge clk);
    check("R10 busy cycles", 128'(busy_cnt), 128'(64));
    expect_lk("R10 flushed flow misses", S2, D2, 3'b000, 0, 1, Z0);
    expect_lk("R10 completion during flush dropped", 0, dsel(60, 1), 3'b000, 0, 1, Z0);
    expect_lk("R10 set-40 flow flushed", 0, dsel(40, 1), 3'b000, 0, 1, Z0);

    report();
  end
endmodule